// File: doc/BRIEF.md
# Integer Operate Unit

This unit executes one 64-bit integer operate-format instruction per transfer. An upstream issue stage presents the instruction word together with the values read for its two source registers and the current value of its destination register. The unit decodes the word, selects either the second register value or an 8-bit literal carried in the word, and computes one of three things: a sum or difference (optionally scaled, optionally folded to a sign-extended 32-bit longword), a signed or unsigned comparison, or a bitwise function. It can also select between the second operand and the old destination value for a conditional move. The result leaves through a one-deep registered output stage with a write-enable, a signed-overflow trap flag and an illegal-instruction flag.

Both edges of the unit are valid/ready streams. An input transfer happens on a rising clock edge when `in_valid` and `in_ready` are both high. `in_ready` is high whenever the output register is empty or is being emptied in the same cycle. Once `in_valid` is raised, the issuer must keep it and the whole payload unchanged until the transfer completes. An output transfer happens when `out_valid` and `out_ready` are both high. While `out_valid` is high and `out_ready` is low, every output holds its value. A result appears on the output one clock edge after its input transfer.

Top module: `iop_unit`

## Requirements
- R1: Instruction fields are opcode [31:26], first source index [25:21], destination index [4:0] and function code [11:5]. When bit 12 is 1, the second operand is the 8-bit literal in [20:13], zero-extended to 64 bits. When bit 12 is 0, the second operand is the register value whose index is in [20:16]. `out_rc` carries the destination index of the instruction.
- R2: A source index of 31 makes that operand zero, whatever value was supplied for it.
- R3: Under opcode 0x10, function 0x20 adds and 0x29 subtracts (second operand from first) over the full 64 bits. Functions 0x00 and 0x09 do the same but return the low 32 bits of the 64-bit result, sign-extended.
- R4: Scaled forms shift the first operand left by 2 or by 3 before adding or subtracting. Add-by-4: 0x22 quad, 0x02 long. Subtract-by-4: 0x2b quad, 0x0b long. Add-by-8: 0x32 quad, 0x12 long. Subtract-by-8: 0x3b quad, 0x1b long.
- R5: Under opcode 0x10, compares write 1 when the condition holds and 0 otherwise. The codes are: equal 0x2d, signed less 0x4d, signed less-or-equal 0x6d, unsigned less 0x1d, unsigned less-or-equal 0x3d.
- R6: Under opcode 0x11, the bitwise functions are 0x00 AND, 0x08 first AND NOT second, 0x20 OR, 0x28 first OR NOT second, 0x40 XOR and 0x48 XNOR.
- R7: Under opcode 0x11, conditional moves test the first operand: 0x24 zero, 0x26 nonzero, 0x44 negative, 0x46 non-negative, 0x64 negative-or-zero, 0x66 positive, 0x16 bit 0 clear, 0x14 bit 0 set. When the condition holds, the result is the second operand and `out_wen` is 1. Otherwise the result is the old destination value and `out_wen` is 0.
- R8: Under opcode 0x10, functions 0x60 and 0x69 (quad) and 0x40 and 0x49 (long) give the same result as 0x20, 0x29, 0x00 and 0x09, and also raise `out_trap` on signed overflow. Long forms judge overflow on the 32-bit result. No other function ever raises `out_trap`.
- R9: The instruction is illegal if any of these holds: the opcode is neither 0x10 nor 0x11; the function code is not listed above; or bit 12 is 0 while [15:13] is nonzero. An illegal instruction gives `out_illegal`=1, `out_wen`=0, `out_trap`=0 and a result of 0. A legal one gives `out_illegal`=0. Every non-move legal instruction gives `out_wen`=1.
- R10: `in_ready` equals NOT `out_valid` OR `out_ready`. A transfer accepted at one edge is presented at the output from that edge on. A stalled output holds all its values.
- R11: During and after reset, `out_valid` is 0 until the first transfer is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Instruction payload present |
| in_ready | output | 1 | Unit can take the payload this cycle |
| in_instr | input | 32 | Operate-format instruction word |
| in_ra_val | input | 64 | Value of the first source register |
| in_rb_val | input | 64 | Value of the second source register |
| in_rc_val | input | 64 | Current value of the destination register |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_rc | output | 5 | Destination register index |
| out_result | output | 64 | Value for the destination register |
| out_wen | output | 1 | Destination should be written |
| out_trap | output | 1 | Signed overflow on a checking variant |
| out_illegal | output | 1 | Instruction not recognised |

## Verification
The properties assume that the issuer obeys the input stream rule: once `in_valid` is raised, the payload and `in_valid` stay unchanged until the transfer completes. The handshake checks would not be meaningful for an issuer that withdraws or alters an offered instruction. The bench keeps to this rule. It changes the payload only in a cycle after an accepted transfer, or while `in_valid` is low. It drives `out_ready` at random, so that stalls of varying length meet both fresh and pending inputs. The operand values lean on the sign, 32-bit and all-ones boundaries where the scaled, longword and overflow behaviour turns.

// File: rtl/iop_pkg.sv
package iop_pkg;

  localparam int unsigned INSTR_W = 32;
  localparam int unsigned IDX_W   = 5;
  localparam int unsigned FUNC_W  = 7;
  localparam int unsigned LIT_W   = 8;

  localparam logic [5:0] OPC_ARITH = 6'h10;
  localparam logic [5:0] OPC_LOGIC = 6'h11;

  typedef enum logic [3:0] {
    K_ADD, K_SUB, K_CMPEQ, K_CMPLT, K_CMPLE, K_CMPULT, K_CMPULE,
    K_AND, K_BIC, K_BIS, K_ORNOT, K_XOR, K_EQV, K_CMOV
  } op_kind_e;

  typedef enum logic [2:0] {
    C_ZERO, C_NONZERO, C_NEG, C_NONNEG, C_NONPOS, C_POS, C_LOWCLR, C_LOWSET
  } cond_e;

  typedef struct packed {
    op_kind_e   kind;
    logic [1:0] shamt;
    logic       long_w;
    logic       chk_ovf;
    cond_e      cond;
    logic       illegal;
  } ctrl_t;

endpackage

// File: rtl/iop_decode.sv
module iop_decode
  import iop_pkg::*;
(
  input  logic [INSTR_W-1:0] instr,
  output ctrl_t              ctrl,
  output logic [IDX_W-1:0]   ra_idx,
  output logic [IDX_W-1:0]   rb_idx,
  output logic [IDX_W-1:0]   rc_idx,
  output logic               lit_sel,
  output logic [LIT_W-1:0]   lit
);

  logic [5:0]        opc;
  logic [FUNC_W-1:0] fn;
  logic              known;
  logic              bad_sbz;

  assign opc     = instr[31:26];
  assign fn      = instr[11:5];
  assign ra_idx  = instr[25:21];
  assign rb_idx  = instr[20:16];
  assign rc_idx  = instr[4:0];
  assign lit_sel = instr[12];
  assign lit     = instr[20:13];
  assign bad_sbz = !instr[12] && (instr[15:13] != 3'b000);

  always_comb begin
    ctrl.kind    = K_ADD;
    ctrl.shamt   = 2'd0;
    ctrl.long_w  = 1'b0;
    ctrl.chk_ovf = 1'b0;
    ctrl.cond    = C_ZERO;
    known        = 1'b1;
    if (opc == OPC_ARITH) begin
      case (fn)
        7'h20: ctrl.kind = K_ADD;
        7'h00: ctrl.long_w = 1'b1;
        7'h29: ctrl.kind = K_SUB;
        7'h09: begin ctrl.kind = K_SUB; ctrl.long_w = 1'b1; end
        7'h22: ctrl.shamt = 2'd2;
        7'h02: begin ctrl.shamt = 2'd2; ctrl.long_w = 1'b1; end
        7'h2b: begin ctrl.kind = K_SUB; ctrl.shamt = 2'd2; end
        7'h0b: begin ctrl.kind = K_SUB; ctrl.shamt = 2'd2; ctrl.long_w = 1'b1; end
        7'h32: ctrl.shamt = 2'd3;
        7'h12: begin ctrl.shamt = 2'd3; ctrl.long_w = 1'b1; end
        7'h3b: begin ctrl.kind = K_SUB; ctrl.shamt = 2'd3; end
        7'h1b: begin ctrl.kind = K_SUB; ctrl.shamt = 2'd3; ctrl.long_w = 1'b1; end
        7'h60: ctrl.chk_ovf = 1'b1;
        7'h40: begin ctrl.long_w = 1'b1; ctrl.chk_ovf = 1'b1; end
        7'h69: begin ctrl.kind = K_SUB; ctrl.chk_ovf = 1'b1; end
        7'h49: begin ctrl.kind = K_SUB; ctrl.long_w = 1'b1; ctrl.chk_ovf = 1'b1; end
        7'h2d: ctrl.kind = K_CMPEQ;
        7'h4d: ctrl.kind = K_CMPLT;
        7'h6d: ctrl.kind = K_CMPLE;
        7'h1d: ctrl.kind = K_CMPULT;
        7'h3d: ctrl.kind = K_CMPULE;
        default: known = 1'b0;
      endcase
    end else if (opc == OPC_LOGIC) begin
      case (fn)
        7'h00: ctrl.kind = K_AND;
        7'h08: ctrl.kind = K_BIC;
        7'h20: ctrl.kind = K_BIS;
        7'h28: ctrl.kind = K_ORNOT;
        7'h40: ctrl.kind = K_XOR;
        7'h48: ctrl.kind = K_EQV;
        7'h24: begin ctrl.kind = K_CMOV; ctrl.cond = C_ZERO;    end
        7'h26: begin ctrl.kind = K_CMOV; ctrl.cond = C_NONZERO; end
        7'h44: begin ctrl.kind = K_CMOV; ctrl.cond = C_NEG;     end
        7'h46: begin ctrl.kind = K_CMOV; ctrl.cond = C_NONNEG;  end
        7'h64: begin ctrl.kind = K_CMOV; ctrl.cond = C_NONPOS;  end
        7'h66: begin ctrl.kind = K_CMOV; ctrl.cond = C_POS;     end
        7'h16: begin ctrl.kind = K_CMOV; ctrl.cond = C_LOWCLR;  end
        7'h14: begin ctrl.kind = K_CMOV; ctrl.cond = C_LOWSET;  end
        default: known = 1'b0;
      endcase
    end else begin
      known = 1'b0;
    end
    ctrl.illegal = !known || bad_sbz;
  end

endmodule

// File: rtl/iop_operands.sv
module iop_operands
  import iop_pkg::*;
#(
  parameter int unsigned XLEN     = 64,
  parameter int unsigned ZERO_IDX = 31
) (
  input  logic [IDX_W-1:0] ra_idx,
  input  logic [IDX_W-1:0] rb_idx,
  input  logic             lit_sel,
  input  logic [LIT_W-1:0] lit,
  input  logic [XLEN-1:0]  ra_val,
  input  logic [XLEN-1:0]  rb_val,
  output logic [XLEN-1:0]  opa,
  output logic [XLEN-1:0]  opb
);

  localparam logic [IDX_W-1:0] ZIDX = IDX_W'(ZERO_IDX);

  logic [XLEN-1:0] lit_ext;
  logic [XLEN-1:0] rb_eff;

  assign lit_ext = {{(XLEN-LIT_W){1'b0}}, lit};
  assign rb_eff  = (rb_idx == ZIDX) ? '0 : rb_val;
  assign opa     = (ra_idx == ZIDX) ? '0 : ra_val;
  assign opb     = lit_sel ? lit_ext : rb_eff;

endmodule

// File: rtl/iop_alu.sv
module iop_alu
  import iop_pkg::*;
#(
  parameter int unsigned XLEN = 64
) (
  input  ctrl_t           ctrl,
  input  logic [XLEN-1:0] opa,
  input  logic [XLEN-1:0] opb,
  input  logic [XLEN-1:0] rc_old,
  output logic [XLEN-1:0] result,
  output logic            wen,
  output logic            trap
);

  localparam int unsigned HALF = XLEN / 2;

  logic [XLEN-1:0] scaled, addend, sum, folded;
  logic            is_sub, ovf_q, ovf_l, ovf;
  logic            eq, slt, ult, a_zero, a_neg, cond_ok;

  assign is_sub = (ctrl.kind == K_SUB);
  assign scaled = opa << ctrl.shamt;
  assign addend = is_sub ? ~opb : opb;
  assign sum    = scaled + addend + {{(XLEN-1){1'b0}}, is_sub};

  assign ovf_q = (scaled[XLEN-1] == addend[XLEN-1]) && (sum[XLEN-1] != scaled[XLEN-1]);
  assign ovf_l = (scaled[HALF-1] == addend[HALF-1]) && (sum[HALF-1] != scaled[HALF-1]);
  assign ovf   = ctrl.long_w ? ovf_l : ovf_q;

  generate
    if (HALF > 0) begin : g_fold
      assign folded = ctrl.long_w ? {{HALF{sum[HALF-1]}}, sum[HALF-1:0]} : sum;
    end
  endgenerate

  assign eq     = (opa == opb);
  assign slt    = ($signed(opa) < $signed(opb));
  assign ult    = (opa < opb);
  assign a_zero = (opa == '0);
  assign a_neg  = opa[XLEN-1];

  always_comb begin
    case (ctrl.cond)
      C_ZERO:    cond_ok = a_zero;
      C_NONZERO: cond_ok = !a_zero;
      C_NEG:     cond_ok = a_neg;
      C_NONNEG:  cond_ok = !a_neg;
      C_NONPOS:  cond_ok = a_neg || a_zero;
      C_POS:     cond_ok = !a_neg && !a_zero;
      C_LOWCLR:  cond_ok = !opa[0];
      default:   cond_ok = opa[0];
    endcase
  end

  always_comb begin
    result = '0;
    case (ctrl.kind)
      K_ADD, K_SUB: result = folded;
      K_CMPEQ:      result[0] = eq;
      K_CMPLT:      result[0] = slt;
      K_CMPLE:      result[0] = slt || eq;
      K_CMPULT:     result[0] = ult;
      K_CMPULE:     result[0] = ult || eq;
      K_AND:        result = opa & opb;
      K_BIC:        result = opa & ~opb;
      K_BIS:        result = opa | opb;
      K_ORNOT:      result = opa | ~opb;
      K_XOR:        result = opa ^ opb;
      K_EQV:        result = ~(opa ^ opb);
      default:      result = cond_ok ? opb : rc_old;
    endcase
    if (ctrl.illegal) result = '0;
  end

  assign wen  = !ctrl.illegal && ((ctrl.kind != K_CMOV) || cond_ok);
  assign trap = !ctrl.illegal && ctrl.chk_ovf && ovf;

endmodule

// File: rtl/iop_outstage.sv
module iop_outstage #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);

  logic         full_q;
  logic [W-1:0] data_q;

  assign in_ready  = !full_q || out_ready;
  assign out_valid = full_q;
  assign out_data  = data_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      data_q <= '0;
    end else if (in_ready) begin
      full_q <= in_valid;
      if (in_valid) data_q <= in_data;
    end
  end

endmodule

// File: rtl/iop_unit.sv
module iop_unit
  import iop_pkg::*;
#(
  parameter int unsigned XLEN = 64
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [INSTR_W-1:0] in_instr,
  input  logic [XLEN-1:0]    in_ra_val,
  input  logic [XLEN-1:0]    in_rb_val,
  input  logic [XLEN-1:0]    in_rc_val,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [IDX_W-1:0]   out_rc,
  output logic [XLEN-1:0]    out_result,
  output logic               out_wen,
  output logic               out_trap,
  output logic               out_illegal
);

  localparam int unsigned PAY_W = IDX_W + XLEN + 3;

  ctrl_t            ctrl;
  logic [IDX_W-1:0] ra_idx, rb_idx, rc_idx;
  logic             lit_sel;
  logic [LIT_W-1:0] lit;
  logic [XLEN-1:0]  opa, opb, res;
  logic             wen, trap;
  logic [PAY_W-1:0] pay_in, pay_out;

  iop_decode u_dec (
    .instr   (in_instr),
    .ctrl    (ctrl),
    .ra_idx  (ra_idx),
    .rb_idx  (rb_idx),
    .rc_idx  (rc_idx),
    .lit_sel (lit_sel),
    .lit     (lit)
  );

  iop_operands #(.XLEN(XLEN)) u_opnd (
    .ra_idx  (ra_idx),
    .rb_idx  (rb_idx),
    .lit_sel (lit_sel),
    .lit     (lit),
    .ra_val  (in_ra_val),
    .rb_val  (in_rb_val),
    .opa     (opa),
    .opb     (opb)
  );

  iop_alu #(.XLEN(XLEN)) u_alu (
    .ctrl    (ctrl),
    .opa     (opa),
    .opb     (opb),
    .rc_old  (in_rc_val),
    .result  (res),
    .wen     (wen),
    .trap    (trap)
  );

  assign pay_in = {rc_idx, res, wen, trap, ctrl.illegal};

  iop_outstage #(.W(PAY_W)) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   (pay_in),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (pay_out)
  );

  assign {out_rc, out_result, out_wen, out_trap, out_illegal} = pay_out;

endmodule

// File: rtl/iop_unit_chk.sv
module iop_unit_chk #(
  parameter int unsigned XLEN = 64
) (
  input logic            clk,
  input logic            rst_n,
  input logic            in_valid,
  input logic            in_ready,
  input logic [5:0]      op_code,
  input logic [6:0]      fn_code,
  input logic [4:0]      rc_field,
  input logic [3:0]      sbz,
  input logic            out_valid,
  input logic            out_ready,
  input logic [4:0]      out_rc,
  input logic [XLEN-1:0] out_result,
  input logic            out_wen,
  input logic            out_trap,
  input logic            out_illegal
);

  localparam int unsigned HALF = XLEN / 2;

  logic accept, long_fn, cmp_fn;
  assign accept  = in_valid && in_ready;
  assign long_fn = (fn_code == 7'h00) || (fn_code == 7'h09) || (fn_code == 7'h02) ||
                   (fn_code == 7'h0b) || (fn_code == 7'h12) || (fn_code == 7'h1b) ||
                   (fn_code == 7'h40) || (fn_code == 7'h49);
  assign cmp_fn  = (fn_code == 7'h2d) || (fn_code == 7'h4d) || (fn_code == 7'h6d) ||
                   (fn_code == 7'h1d) || (fn_code == 7'h3d);

  a_r10_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_result) && $stable(out_rc) &&
                                $stable(out_wen) && $stable(out_trap) && $stable(out_illegal));

  a_r10_accept_shows: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> out_valid);

  a_r10_empty_ready: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready);

  a_r1_dest_index: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> out_rc == $past(rc_field));

  a_r3_long_sext: assert property (@(posedge clk) disable iff (!rst_n)
    accept && op_code == 6'h10 && long_fn |=>
      out_result[XLEN-1:HALF] == {HALF{out_result[HALF-1]}});

  a_r5_cmp_bool: assert property (@(posedge clk) disable iff (!rst_n)
    accept && op_code == 6'h10 && cmp_fn |=> out_result[XLEN-1:1] == '0);

  a_r8_logic_no_trap: assert property (@(posedge clk) disable iff (!rst_n)
    accept && op_code == 6'h11 |=> !out_trap);

  a_r9_sbz_illegal: assert property (@(posedge clk) disable iff (!rst_n)
    accept && !sbz[0] && (sbz[3:1] != 3'b000) |=> out_illegal && !out_wen);

  a_r9_illegal_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_illegal |-> !out_wen && !out_trap && out_result == '0);

endmodule

bind iop_unit iop_unit_chk #(.XLEN(XLEN)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_valid    (in_valid),
  .in_ready    (in_ready),
  .op_code     (in_instr[31:26]),
  .fn_code     (in_instr[11:5]),
  .rc_field    (in_instr[4:0]),
  .sbz         (in_instr[15:12]),
  .out_valid   (out_valid),
  .out_ready   (out_ready),
  .out_rc      (out_rc),
  .out_result  (out_result),
  .out_wen     (out_wen),
  .out_trap    (out_trap),
  .out_illegal (out_illegal)
);

// File: tb/sim_iop_unit.sv
`timescale 1ns/1ps
module sim_iop_unit;

  localparam int XLEN = 64;
  localparam int NVEC = 3000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid, in_ready, out_valid, out_ready;
  logic [31:0] in_instr;
  logic [63:0] in_ra_val, in_rb_val, in_rc_val, out_result;
  logic [4:0]  out_rc;
  logic        out_wen, out_trap, out_illegal;

  always #2 clk = ~clk;

  iop_unit #(.XLEN(XLEN)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_instr(in_instr), .in_ra_val(in_ra_val), .in_rb_val(in_rb_val),
    .in_rc_val(in_rc_val), .out_valid(out_valid), .out_ready(out_ready),
    .out_rc(out_rc), .out_result(out_result), .out_wen(out_wen),
    .out_trap(out_trap), .out_illegal(out_illegal)
  );

  typedef struct {
    logic [63:0] res;
    logic [4:0]  rc;
    logic        wen, trap, ill;
    string       tag;
  } exp_t;

  exp_t expq[$];
  int vectors = 0;
  int miscompares = 0;

  logic [6:0] arith_fn [21] = '{7'h00, 7'h20, 7'h09, 7'h29, 7'h02, 7'h22, 7'h0b,
                                7'h2b, 7'h12, 7'h32, 7'h1b, 7'h3b, 7'h2d, 7'h4d,
                                7'h6d, 7'h1d, 7'h3d, 7'h40, 7'h60, 7'h49, 7'h69};
  logic [6:0] logic_fn [14] = '{7'h00, 7'h08, 7'h20, 7'h28, 7'h40, 7'h48, 7'h24,
                                7'h26, 7'h44, 7'h46, 7'h64, 7'h66, 7'h16, 7'h14};

  function automatic logic [63:0] sx32(input logic [63:0] x);
    return {{32{x[31]}}, x[31:0]};
  endfunction

  function automatic logic ovq(input logic [63:0] a, input logic [63:0] b, input logic sub);
    logic signed [64:0] s;
    s = sub ? ($signed({a[63], a}) - $signed({b[63], b})) : ($signed({a[63], a}) + $signed({b[63], b}));
    return s[64] != s[63];
  endfunction

  function automatic logic ovl(input logic [63:0] a, input logic [63:0] b, input logic sub);
    logic signed [32:0] s;
    s = sub ? ($signed({a[31], a[31:0]}) - $signed({b[31], b[31:0]})) : ($signed({a[31], a[31:0]}) + $signed({b[31], b[31:0]}));
    return s[32] != s[31];
  endfunction

  function automatic exp_t model(input logic [31:0] ins, input logic [63:0] av,
                                 input logic [63:0] bv, input logic [63:0] cv);
    exp_t e;
    logic [63:0] a, b;
    logic c;
    string t;
    a = (ins[25:21] == 5'd31) ? 64'd0 : av;
    b = ins[12] ? {56'd0, ins[20:13]} : ((ins[20:16] == 5'd31) ? 64'd0 : bv);
    e.rc = ins[4:0]; e.wen = 1'b1; e.trap = 1'b0; e.ill = 1'b0; e.res = 64'd0;
    t = "R9";
    c = 1'b0;
    if (!ins[12] && ins[15:13] != 3'd0) e.ill = 1'b1;
    else if (ins[31:26] == 6'h10) begin
      case (ins[11:5])
        7'h00: begin e.res = sx32(a + b); t = "R3"; end
        7'h20: begin e.res = a + b; t = "R3"; end
        7'h09: begin e.res = sx32(a - b); t = "R3"; end
        7'h29: begin e.res = a - b; t = "R3"; end
        7'h02: begin e.res = sx32((a << 2) + b); t = "R4"; end
        7'h22: begin e.res = (a << 2) + b; t = "R4"; end
        7'h0b: begin e.res = sx32((a << 2) - b); t = "R4"; end
        7'h2b: begin e.res = (a << 2) - b; t = "R4"; end
        7'h12: begin e.res = sx32((a << 3) + b); t = "R4"; end
        7'h32: begin e.res = (a << 3) + b; t = "R4"; end
        7'h1b: begin e.res = sx32((a << 3) - b); t = "R4"; end
        7'h3b: begin e.res = (a << 3) - b; t = "R4"; end
        7'h2d: begin e.res = {63'd0, a == b}; t = "R5"; end
        7'h4d: begin e.res = {63'd0, $signed(a) < $signed(b)}; t = "R5"; end
        7'h6d: begin e.res = {63'd0, $signed(a) <= $signed(b)}; t = "R5"; end
        7'h1d: begin e.res = {63'd0, a < b}; t = "R5"; end
        7'h3d: begin e.res = {63'd0, a <= b}; t = "R5"; end
        7'h40: begin e.res = sx32(a + b); e.trap = ovl(a, b, 1'b0); t = "R8"; end
        7'h60: begin e.res = a + b; e.trap = ovq(a, b, 1'b0); t = "R8"; end
        7'h49: begin e.res = sx32(a - b); e.trap = ovl(a, b, 1'b1); t = "R8"; end
        7'h69: begin e.res = a - b; e.trap = ovq(a, b, 1'b1); t = "R8"; end
        default: e.ill = 1'b1;
      endcase
    end else if (ins[31:26] == 6'h11) begin
      t = "R6";
      case (ins[11:5])
        7'h00: e.res = a & b;
        7'h08: e.res = a & ~b;
        7'h20: e.res = a | b;
        7'h28: e.res = a | ~b;
        7'h40: e.res = a ^ b;
        7'h48: e.res = ~(a ^ b);
        7'h24, 7'h26, 7'h44, 7'h46, 7'h64, 7'h66, 7'h16, 7'h14: begin
          t = "R7";
          case (ins[11:5])
            7'h24: c = (a == 0);
            7'h26: c = (a != 0);
            7'h44: c = ($signed(a) < 0);
            7'h46: c = ($signed(a) >= 0);
            7'h64: c = ($signed(a) <= 0);
            7'h66: c = ($signed(a) > 0);
            7'h16: c = !a[0];
            default: c = a[0];
          endcase
          e.res = c ? b : cv;
          e.wen = c;
        end
        default: e.ill = 1'b1;
      endcase
    end else e.ill = 1'b1;
    if (e.ill) begin e.wen = 1'b0; e.res = 64'd0; t = "R9"; end
    if (ins[12]) t = {t, "/R1"};
    if (ins[25:21] == 5'd31 || (!ins[12] && ins[20:16] == 5'd31)) t = {t, "/R2"};
    e.tag = t;
    return e;
  endfunction

  function automatic logic [63:0] pick_val();
    case ($urandom % 9)
      0: return 64'd0;
      1: return '1;
      2: return 64'h7fffffffffffffff;
      3: return 64'h8000000000000000;
      4: return 64'h000000007fffffff;
      5: return 64'hffffffff80000000;
      6: return 64'($urandom % 4);
      7: return 64'h1fffffffffffffff;
      default: return {$urandom, $urandom};
    endcase
  endfunction

  function automatic logic [31:0] mk(input logic [5:0] opc, input logic [6:0] fn,
                                     input logic [4:0] ra, input logic [4:0] rb,
                                     input logic [4:0] rc, input logic ls, input logic [7:0] lit);
    if (ls) return {opc, ra, lit, 1'b1, fn, rc};
    return {opc, ra, rb, 3'b000, 1'b0, fn, rc};
  endfunction

  task automatic new_vector(input int idx);
    logic [5:0] opc;
    logic [6:0] fn;
    in_ra_val = pick_val();
    in_rb_val = pick_val();
    in_rc_val = {$urandom, $urandom};
    case (idx)
      0: begin in_instr = mk(6'h10, 7'h60, 5'd1, 5'd2, 5'd3, 1'b0, 8'd0);
               in_ra_val = 64'h7fffffffffffffff; in_rb_val = 64'd1; end
      1: begin in_instr = mk(6'h10, 7'h40, 5'd4, 5'd5, 5'd6, 1'b0, 8'd0);
               in_ra_val = 64'h000000007fffffff; in_rb_val = 64'd1; end
      2: begin in_instr = mk(6'h10, 7'h00, 5'd7, 5'd0, 5'd8, 1'b1, 8'hff);
               in_ra_val = 64'hffffffff00000001; end
      3: begin in_instr = mk(6'h10, 7'h3b, 5'd9, 5'd10, 5'd11, 1'b0, 8'd0);
               in_ra_val = 64'h2000000000000001; in_rb_val = 64'd9; end
      4: begin in_instr = mk(6'h10, 7'h1d, 5'd31, 5'd12, 5'd13, 1'b0, 8'd0);
               in_ra_val = '1; in_rb_val = 64'd1; end
      5: begin in_instr = mk(6'h11, 7'h14, 5'd14, 5'd31, 5'd15, 1'b0, 8'd0);
               in_ra_val = 64'd2; in_rb_val = 64'd77; end
      6: begin in_instr = mk(6'h11, 7'h20, 5'd1, 5'd2, 5'd3, 1'b0, 8'd0) | 32'h0000_4000; end
      7: begin in_instr = mk(6'h12, 7'h00, 5'd1, 5'd2, 5'd3, 1'b0, 8'd0); end
      8: begin in_instr = mk(6'h10, 7'h69, 5'd1, 5'd2, 5'd3, 1'b0, 8'd0);
               in_ra_val = 64'd0; in_rb_val = 64'h8000000000000000; end
      default: begin
        opc = ($urandom % 2 == 0) ? 6'h10 : 6'h11;
        fn  = (opc == 6'h10) ? arith_fn[$urandom % 21] : logic_fn[$urandom % 14];
        if ($urandom % 16 == 0) fn = 7'($urandom);
        if ($urandom % 32 == 0) opc = 6'($urandom);
        in_instr = mk(opc, fn, 5'($urandom), 5'($urandom), 5'($urandom),
                      1'($urandom), 8'($urandom));
        if (!in_instr[12] && $urandom % 16 == 0) in_instr[15:13] = 3'($urandom);
      end
    endcase
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    vectors++; miscompares++;
    $display("FAIL R10 watchdog: actual=hung expected=drained");
    finish_run();
  end

  initial begin
    int sent = 0;
    logic accepted = 1'b1;
    logic held = 1'b0;
    logic [63:0] h_res;
    logic [4:0]  h_rc;
    logic [2:0]  h_flags;
    exp_t e;
    rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b0;
    in_instr = '0; in_ra_val = '0; in_rb_val = '0; in_rc_val = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    vectors++;
    if (out_valid !== 1'b0 || in_ready !== 1'b1) begin
      miscompares++;
      $display("FAIL R11 reset: actual valid=%b ready=%b expected valid=0 ready=1", out_valid, in_ready);
    end
    while (sent < NVEC || expq.size() != 0 || out_valid) begin
      @(negedge clk);
      if (held && out_valid) begin
        vectors++;
        if (out_result !== h_res || out_rc !== h_rc ||
            {out_wen, out_trap, out_illegal} !== h_flags) begin
          miscompares++;
          $display("FAIL R10 stall hold: actual %h/%0d/%b expected %h/%0d/%b",
                   out_result, out_rc, {out_wen, out_trap, out_illegal}, h_res, h_rc, h_flags);
        end
      end
      out_ready = (sent >= NVEC) ? 1'b1 : ($urandom % 4 != 0);
      if (!(in_valid && !accepted)) begin
        if (sent < NVEC && ($urandom % 5 != 0)) begin
          in_valid = 1'b1;
          new_vector(sent);
        end else in_valid = 1'b0;
      end
      #1;
      if (out_valid && out_ready) begin
        vectors++;
        if (expq.size() == 0) begin
          miscompares++;
          $display("FAIL R10 extra output: actual rc=%0d expected none", out_rc);
        end else begin
          e = expq.pop_front();
          if (out_result !== e.res || out_rc !== e.rc || out_wen !== e.wen ||
              out_trap !== e.trap || out_illegal !== e.ill) begin
            miscompares++;
            $display("FAIL %s: actual res=%h rc=%0d wen=%b trap=%b ill=%b expected res=%h rc=%0d wen=%b trap=%b ill=%b",
                     e.tag, out_result, out_rc, out_wen, out_trap, out_illegal,
                     e.res, e.rc, e.wen, e.trap, e.ill);
          end
        end
      end
      vectors++;
      if (in_ready !== (!out_valid || out_ready)) begin
        miscompares++;
        $display("FAIL R10 ready: actual %b expected %b", in_ready, !out_valid || out_ready);
      end
      held = out_valid && !out_ready;
      h_res = out_result; h_rc = out_rc; h_flags = {out_wen, out_trap, out_illegal};
      if (in_valid && in_ready) begin
        expq.push_back(model(in_instr, in_ra_val, in_rb_val, in_rc_val));
        sent++;
        accepted = 1'b1;
      end else accepted = !in_valid;
    end
    finish_run();
  end

endmodule